// File: doc/BRIEF.md
# Page Access Permission Evaluator

This block decides what a translated page may be used for and whether the access at hand is allowed. It takes the protection fields of a page table entry, the two key bits of the segment holding the page, the current privilege state, the page's no-execute and guarded flags, and two 64-bit key-indexed mask registers. One mask gates data loads and stores, the other gates instruction fetch. From these it forms three rights masks, each made only of read, write and execute bits, and combines them with a bitwise AND.

The requested access type is then checked against the combined rights. A miss raises a fault flag together with reason bits for the fetch-fault status or the data-fault status. The table walk and the update of referenced and changed bits are outside the block. The result is registered by default. A parameter removes the register, and two further parameters select whether key-based protection and the fetch mask are implemented at all.

Top module: `pgperm_eval`

## Requirements
- R1: The segment key in force is `seg_key_user` when `user_mode` is 1 and `seg_key_sup` when `user_mode` is 0.
- R2: The protection code is {`pp_hi`, `pp_lo[1]`, `pp_lo[0]`}. Under key 0, codes 0, 1 and 2 grant read, write and execute, and codes 3 and 6 grant read and execute.
- R3: Under key 1, code 2 grants read, write and execute, codes 1, 3 and 6 grant read and execute, and code 0 grants nothing.
- R4: Codes 4, 5 and 7 grant nothing under either key.
- R5: When `no_exec` or `guarded` is 1, execute is withdrawn and read and write are left as they are.
- R6: For page key k, data mask bit 2*(2^KEY_W-1-k)+1 withdraws write and bit 2*(2^KEY_W-1-k) withdraws read. This mask never withdraws execute.
- R7: For page key k, fetch mask bit 2*(2^KEY_W-1-k) withdraws execute only, and fetch mask bit 2*(2^KEY_W-1-k)+1 has no effect.
- R8: With KEY_PROT_EN=0, both mask registers are ignored.
- R9: The rights reported on `allow_r`/`allow_w`/`allow_x` are the AND of the three masks. `req_kind` is encoded as 0 read, 1 write, 2 fetch, 3 no access. `fault` is 1 exactly when the right the request needs is missing, so kind 3 never faults.
- R10: On a fetch fault, `ifault_noexec` is set when no-execute/guard removed execute. Otherwise `ifault_prot` is set when the protection code lacks execute. `ifault_imask` is set independently when the fetch mask removed execute. The data reason bits stay 0.
- R11: On a read or write fault, `dfault_prot` is set when the protection code lacks the right and `dfault_amask` is set when the data mask lacks it. `dfault_store` is set on write faults. The fetch reason bits stay 0. Without a fault, all reason bits are 0.
- R12: With OUT_REG=1, results appear one clock after the request, with `rsp_valid` high. Whenever `rsp_valid` is low, and throughout reset, all rights, fault and reason outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 no access |
| user_mode | input | 1 | 1 when running unprivileged |
| seg_key_user | input | 1 | Segment key used in user mode |
| seg_key_sup | input | 1 | Segment key used in privileged mode |
| pp_hi | input | 1 | High bit of the protection code |
| pp_lo | input | 2 | Low two bits of the protection code |
| no_exec | input | 1 | Page is marked no-execute |
| guarded | input | 1 | Page is marked guarded |
| page_key | input | KEY_W | Page key indexing the mask registers |
| amask_reg | input | 2*2^KEY_W | Data authority mask register |
| imask_reg | input | 2*2^KEY_W | Fetch authority mask register |
| rsp_valid | output | 1 | Result outputs are valid |
| allow_r | output | 1 | Read granted |
| allow_w | output | 1 | Write granted |
| allow_x | output | 1 | Execute granted |
| fault | output | 1 | Requested right is missing |
| ifault_noexec | output | 1 | Fetch fault caused by no-execute/guard |
| ifault_prot | output | 1 | Fetch fault caused by the protection code |
| ifault_imask | output | 1 | Fetch fault caused by the fetch mask |
| dfault_prot | output | 1 | Data fault caused by the protection code |
| dfault_store | output | 1 | Data fault occurred on a write |
| dfault_amask | output | 1 | Data fault caused by the data mask |

## Verification
The bench sweeps every protection code under both keys and all access kinds. A decoder that swaps the key-1 entries for codes 0 and 2, or that lets an undefined code grant rights, would return wrong rights or a missing fault.

It places single mask bits at both ends of the key range and checks three things: a mis-computed offset would fault the wrong key, swapped read/write bits would fault the wrong access, and using the fetch mask's high bit would kill execute where it must survive.

Fetches that are both guarded and blocked by the protection code check that only the no-execute reason is reported. A second instance built without key protection, fed the same stimulus, catches a design that still lets the masks take effect.

// File: rtl/pgperm_pkg.sv
package pgperm_pkg;

   localparam int RIGHT_R = 0;
   localparam int RIGHT_W = 1;
   localparam int RIGHT_X = 2;

   typedef logic [2:0] rights_t;

   localparam rights_t RIGHTS_ALL  = 3'b111;
   localparam rights_t RIGHTS_RX   = 3'b101;
   localparam rights_t RIGHTS_RW   = 3'b011;
   localparam rights_t RIGHTS_NONE = 3'b000;

   typedef enum logic [1:0] {
      ACC_READ  = 2'd0,
      ACC_WRITE = 2'd1,
      ACC_FETCH = 2'd2,
      ACC_NONE  = 2'd3
   } acc_kind_e;

   typedef struct packed {
      rights_t allow;
      logic    fault;
      logic    ifl_noexec;
      logic    ifl_prot;
      logic    ifl_imask;
      logic    dfl_prot;
      logic    dfl_store;
      logic    dfl_amask;
   } perm_res_t;

   function automatic rights_t need_of(acc_kind_e k);
      case (k)
         ACC_READ:  need_of = 3'b001;
         ACC_WRITE: need_of = 3'b010;
         ACC_FETCH: need_of = 3'b100;
         default:   need_of = 3'b000;
      endcase
   endfunction

endpackage

// File: rtl/pgperm_pp_decode.sv
module pgperm_pp_decode
   import pgperm_pkg::*;
(
   input  logic       seg_key,
   input  logic [2:0] code,
   output rights_t    rights
);

   always_comb begin
      rights = RIGHTS_NONE;
      if (!seg_key) begin
         case (code)
            3'd0, 3'd1, 3'd2: rights = RIGHTS_ALL;
            3'd3, 3'd6:       rights = RIGHTS_RX;
            default:          rights = RIGHTS_NONE;
         endcase
      end else begin
         case (code)
            3'd2:             rights = RIGHTS_ALL;
            3'd1, 3'd3, 3'd6: rights = RIGHTS_RX;
            default:          rights = RIGHTS_NONE;
         endcase
      end
   end

endmodule

// File: rtl/pgperm_key_mask.sv
module pgperm_key_mask
   import pgperm_pkg::*;
#(
   parameter int KEY_W         = 5,
   parameter bit KEY_PROT_EN   = 1'b1,
   parameter bit INSTR_MASK_EN = 1'b1
) (
   input  logic [KEY_W-1:0]          key,
   input  logic [2*(2**KEY_W)-1:0]   amask,
   input  logic [2*(2**KEY_W)-1:0]   imask,
   output rights_t                   rights
);

   localparam int NKEYS  = 2 ** KEY_W;
   localparam int MASK_W = 2 * NKEYS;

   // Field offset 2*(NKEYS-1-key) equals the inverted key shifted left once.
   logic [KEY_W:0] fld_off;
   assign fld_off = {~key, 1'b0};

   generate
      if (KEY_PROT_EN) begin : g_keyed
         logic [1:0] dfield;
         logic       xblock;
         assign dfield = amask[fld_off +: 2];
         if (INSTR_MASK_EN) begin : g_imask
            logic unused_ihi;
            assign xblock    = imask[fld_off];
            assign unused_ihi = ^imask[MASK_W-1:0] & 1'b0;
         end else begin : g_no_imask
            logic unused_imask;
            assign xblock       = 1'b0;
            assign unused_imask = ^imask;
         end
         always_comb begin
            rights          = RIGHTS_ALL;
            rights[RIGHT_W] = ~dfield[1];
            rights[RIGHT_R] = ~dfield[0];
            rights[RIGHT_X] = ~xblock;
         end
      end else begin : g_unkeyed
         logic unused_inputs;
         assign unused_inputs = ^{amask, imask, fld_off};
         assign rights        = RIGHTS_ALL;
      end
   endgenerate

endmodule

// File: rtl/pgperm_fault_enc.sv
module pgperm_fault_enc
   import pgperm_pkg::*;
(
   input  logic      valid,
   input  acc_kind_e kind,
   input  rights_t   ng_rights,
   input  rights_t   pp_rights,
   input  rights_t   key_rights,
   output perm_res_t res
);

   rights_t need;
   rights_t allow;
   rights_t miss;

   assign need  = need_of(kind);
   assign allow = ng_rights & pp_rights & key_rights;
   assign miss  = need & ~allow;

   always_comb begin
      res = '0;
      if (valid) begin
         res.allow = allow;
         res.fault = |miss;
         if (|miss) begin
            if (kind == ACC_FETCH) begin
               res.ifl_noexec = ~ng_rights[RIGHT_X];
               res.ifl_prot   = ng_rights[RIGHT_X] & ~pp_rights[RIGHT_X];
               res.ifl_imask  = ~key_rights[RIGHT_X];
            end else begin
               res.dfl_prot  = |(need & ~pp_rights);
               res.dfl_store = (kind == ACC_WRITE);
               res.dfl_amask = |(need & ~key_rights);
            end
         end
      end
   end

endmodule

// File: rtl/pgperm_eval.sv
module pgperm_eval
   import pgperm_pkg::*;
#(
   parameter int KEY_W         = 5,
   parameter bit KEY_PROT_EN   = 1'b1,
   parameter bit INSTR_MASK_EN = 1'b1,
   parameter bit OUT_REG       = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      req_valid,
   input  logic [1:0]                req_kind,
   input  logic                      user_mode,
   input  logic                      seg_key_user,
   input  logic                      seg_key_sup,
   input  logic                      pp_hi,
   input  logic [1:0]                pp_lo,
   input  logic                      no_exec,
   input  logic                      guarded,
   input  logic [KEY_W-1:0]          page_key,
   input  logic [2*(2**KEY_W)-1:0]   amask_reg,
   input  logic [2*(2**KEY_W)-1:0]   imask_reg,
   output logic                      rsp_valid,
   output logic                      allow_r,
   output logic                      allow_w,
   output logic                      allow_x,
   output logic                      fault,
   output logic                      ifault_noexec,
   output logic                      ifault_prot,
   output logic                      ifault_imask,
   output logic                      dfault_prot,
   output logic                      dfault_store,
   output logic                      dfault_amask
);

   generate
      if (KEY_W < 1 || KEY_W > 6) begin : g_bad_key_w
         $error("pgperm_eval: KEY_W must lie in 1..6");
      end
   endgenerate

   logic      seg_key;
   logic [2:0] code;
   rights_t   pp_rights;
   rights_t   ng_rights;
   rights_t   key_rights;
   perm_res_t res_d;
   perm_res_t res_q;
   logic      vld_q;

   assign seg_key = user_mode ? seg_key_user : seg_key_sup;
   assign code    = {pp_hi, pp_lo};

   always_comb begin
      ng_rights = RIGHTS_ALL;
      if (no_exec || guarded) ng_rights = RIGHTS_RW;
   end

   pgperm_pp_decode u_pp (
      .seg_key (seg_key),
      .code    (code),
      .rights  (pp_rights)
   );

   pgperm_key_mask #(
      .KEY_W         (KEY_W),
      .KEY_PROT_EN   (KEY_PROT_EN),
      .INSTR_MASK_EN (INSTR_MASK_EN)
   ) u_key (
      .key    (page_key),
      .amask  (amask_reg),
      .imask  (imask_reg),
      .rights (key_rights)
   );

   pgperm_fault_enc u_flt (
      .valid      (req_valid),
      .kind       (acc_kind_e'(req_kind)),
      .ng_rights  (ng_rights),
      .pp_rights  (pp_rights),
      .key_rights (key_rights),
      .res        (res_d)
   );

   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               res_q <= '0;
               vld_q <= 1'b0;
            end else begin
               res_q <= res_d;
               vld_q <= req_valid;
            end
         end

         // R4: undefined protection codes never grant a right
         a_r4_undef_code_none: assert property (@(posedge clk) disable iff (!rst_n)
            (rsp_valid && ($past(code) == 3'd4 || $past(code) == 3'd5 || $past(code) == 3'd7))
            |-> ({allow_x, allow_w, allow_r} == 3'b000));

         // R5: no-execute or guarded page never reports execute
         a_r5_noexec_drops_x: assert property (@(posedge clk) disable iff (!rst_n)
            (rsp_valid && $past(no_exec || guarded)) |-> !allow_x);

         // R11: store reason only follows a faulting write request
         a_r11_store_on_write: assert property (@(posedge clk) disable iff (!rst_n)
            dfault_store |-> (fault && $past(req_kind) == 2'd1));
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk & rst_n;
         assign res_q      = res_d;
         assign vld_q      = req_valid;
      end
   endgenerate

   assign rsp_valid     = vld_q;
   assign allow_r       = res_q.allow[RIGHT_R];
   assign allow_w       = res_q.allow[RIGHT_W];
   assign allow_x       = res_q.allow[RIGHT_X];
   assign fault         = res_q.fault;
   assign ifault_noexec = res_q.ifl_noexec;
   assign ifault_prot   = res_q.ifl_prot;
   assign ifault_imask  = res_q.ifl_imask;
   assign dfault_prot   = res_q.dfl_prot;
   assign dfault_store  = res_q.dfl_store;
   assign dfault_amask  = res_q.dfl_amask;

   // R10: a fetch fault reports at most one of no-execute and protection
   a_r10_single_primary: assert property (@(posedge clk) disable iff (!rst_n)
      !(ifault_noexec && ifault_prot));

   // R9: a fault is only raised alongside a valid result
   a_r9_fault_has_valid: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> rsp_valid);

   // R12: idle cycles keep every result output low
   a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> !(allow_r || allow_w || allow_x || fault || ifault_imask || dfault_amask));

endmodule

// File: tb/pgperm_eval_tb_top.sv
`timescale 1ns/1ps
module pgperm_eval_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_kind = '0;
   logic        user_mode = 1'b0, seg_key_user = 1'b0, seg_key_sup = 1'b0;
   logic        pp_hi = 1'b0;
   logic [1:0]  pp_lo = '0;
   logic        no_exec = 1'b0, guarded = 1'b0;
   logic [4:0]  page_key = '0;
   logic [63:0] amask_reg = '0, imask_reg = '0;

   logic rsp_valid, allow_r, allow_w, allow_x, fault;
   logic ifault_noexec, ifault_prot, ifault_imask, dfault_prot, dfault_store, dfault_amask;
   logic nk_valid, nk_r, nk_w, nk_x, nk_fault;
   logic nk_ine, nk_ipr, nk_iim, nk_dpr, nk_dst, nk_dam;

   int checks = 0;
   int errors = 0;
   logic [13:0] q_exp[$];
   string       q_tag[$];

   always #2.5 clk = ~clk;

   pgperm_eval dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
      .user_mode(user_mode), .seg_key_user(seg_key_user), .seg_key_sup(seg_key_sup),
      .pp_hi(pp_hi), .pp_lo(pp_lo), .no_exec(no_exec), .guarded(guarded),
      .page_key(page_key), .amask_reg(amask_reg), .imask_reg(imask_reg),
      .rsp_valid(rsp_valid), .allow_r(allow_r), .allow_w(allow_w), .allow_x(allow_x),
      .fault(fault), .ifault_noexec(ifault_noexec), .ifault_prot(ifault_prot),
      .ifault_imask(ifault_imask), .dfault_prot(dfault_prot),
      .dfault_store(dfault_store), .dfault_amask(dfault_amask));

   pgperm_eval #(.KEY_PROT_EN(1'b0), .INSTR_MASK_EN(1'b0)) dut_nokey_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
      .user_mode(user_mode), .seg_key_user(seg_key_user), .seg_key_sup(seg_key_sup),
      .pp_hi(pp_hi), .pp_lo(pp_lo), .no_exec(no_exec), .guarded(guarded),
      .page_key(page_key), .amask_reg(amask_reg), .imask_reg(imask_reg),
      .rsp_valid(nk_valid), .allow_r(nk_r), .allow_w(nk_w), .allow_x(nk_x),
      .fault(nk_fault), .ifault_noexec(nk_ine), .ifault_prot(nk_ipr),
      .ifault_imask(nk_iim), .dfault_prot(nk_dpr),
      .dfault_store(nk_dst), .dfault_amask(nk_dam));

   // Reference model: rights as {X,W,R}
   function automatic logic [2:0] ref_pp(input logic k, input logic [2:0] c);
      if (k == 1'b0) begin
         if (c == 0 || c == 1 || c == 2) return 3'b111;
         if (c == 3 || c == 6) return 3'b101;
         return 3'b000;
      end
      if (c == 2) return 3'b111;
      if (c == 1 || c == 3 || c == 6) return 3'b101;
      return 3'b000;
   endfunction

   task automatic check(input string tag, input string what, input logic [13:0] act, input logic [13:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic drive(input logic [1:0] kind, input logic um, input logic ku, input logic ks,
                        input logic [2:0] c, input logic ne, input logic gd, input logic [4:0] k,
                        input logic [63:0] am, input logic [63:0] im, input string tag);
      logic [2:0] pp, ng, km, all, nk_all, need;
      logic [5:0] rsn;
      logic flt, nkf;
      int off;
      @(negedge clk);
      req_valid = 1'b1; req_kind = kind; user_mode = um; seg_key_user = ku; seg_key_sup = ks;
      {pp_hi, pp_lo} = c; no_exec = ne; guarded = gd; page_key = k; amask_reg = am; imask_reg = im;
      pp  = ref_pp(um ? ku : ks, c);
      ng  = (ne || gd) ? 3'b011 : 3'b111;
      off = 2 * (31 - int'(k));
      km  = 3'b111;
      if (am[off+1]) km[1] = 1'b0;
      if (am[off])   km[0] = 1'b0;
      if (im[off])   km[2] = 1'b0;
      need = (kind == 2'd0) ? 3'b001 : (kind == 2'd1) ? 3'b010 : (kind == 2'd2) ? 3'b100 : 3'b000;
      all = ng & pp & km;
      nk_all = ng & pp;
      flt = |(need & ~all);
      nkf = |(need & ~nk_all);
      rsn = '0;
      if (flt && kind == 2'd2) begin
         rsn[5] = !ng[2];
         rsn[4] = ng[2] && !pp[2];
         rsn[3] = !km[2];
      end else if (flt) begin
         rsn[2] = |(need & ~pp);
         rsn[1] = (kind == 2'd1);
         rsn[0] = |(need & ~km);
      end
      q_exp.push_back({all, flt, rsn, nk_all, nkf});
      q_tag.push_back(tag);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         req_valid = 1'b0;
      end
   endtask

   // Monitor: pops expectations as results appear
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         if (q_exp.size() == 0) begin
            check("R12", "unexpected rsp_valid", 14'd1, 14'd0);
         end else begin
            logic [13:0] e;
            string t;
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            check(t, "rights", {11'd0, allow_x, allow_w, allow_r}, {11'd0, e[13:11]});
            check(t, "fault+reasons", {7'd0, fault, ifault_noexec, ifault_prot, ifault_imask,
                  dfault_prot, dfault_store, dfault_amask}, {7'd0, e[10:4]});
            check({t, " R8"}, "no-key rights+fault", {10'd0, nk_x, nk_w, nk_r, nk_fault},
                  {10'd0, e[3:0]});
         end
      end
   end

   task automatic finish_run;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #(5.0 * 150000);
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R12: reset state
      check("R12", "reset outputs", {3'd0, rsp_valid, allow_r, allow_w, allow_x, fault,
            ifault_noexec, ifault_prot, ifault_imask, dfault_prot, dfault_store, dfault_amask}, 14'd0);
      rst_n = 1'b1;
      idle(2);
      check("R12", "idle outputs", {10'd0, rsp_valid, allow_r, fault, dfault_amask}, 14'd0);

      // R1: key selection by privilege
      drive(2'd0, 1'b1, 1'b1, 1'b0, 3'd0, 0, 0, 5'd0, 64'd0, 64'd0, "R1");
      drive(2'd0, 1'b0, 1'b1, 1'b0, 3'd0, 0, 0, 5'd0, 64'd0, 64'd0, "R1");
      drive(2'd1, 1'b0, 1'b0, 1'b1, 3'd0, 0, 0, 5'd0, 64'd0, 64'd0, "R1");
      drive(2'd1, 1'b1, 1'b0, 1'b1, 3'd0, 0, 0, 5'd0, 64'd0, 64'd0, "R1");

      // R2 R3 R4: every code, both keys, every access kind
      for (int ky = 0; ky < 2; ky++)
         for (int cd = 0; cd < 8; cd++)
            for (int kd = 0; kd < 3; kd++) begin
               string t;
               if (cd == 4 || cd == 5 || cd == 7) t = "R4";
               else if (ky == 0) t = "R2";
               else t = "R3";
               drive(2'(kd), 1'b0, 1'b0, 1'(ky), 3'(cd), 0, 0, 5'd7, 64'd0, 64'd0, t);
            end

      // R5: no-execute and guarded strip execute only
      drive(2'd2, 0, 0, 0, 3'd2, 1, 0, 5'd0, 64'd0, 64'd0, "R5 R10");
      drive(2'd2, 0, 0, 0, 3'd2, 0, 1, 5'd0, 64'd0, 64'd0, "R5 R10");
      drive(2'd1, 0, 0, 0, 3'd2, 1, 1, 5'd0, 64'd0, 64'd0, "R5");
      drive(2'd0, 0, 0, 0, 3'd3, 0, 1, 5'd0, 64'd0, 64'd0, "R5");

      // R6: data mask offsets at both ends of the key range
      drive(2'd1, 0, 0, 0, 3'd0, 0, 0, 5'd3, 64'd1 << 57, 64'd0, "R6 R11");
      drive(2'd0, 0, 0, 0, 3'd0, 0, 0, 5'd3, 64'd1 << 57, 64'd0, "R6");
      drive(2'd0, 0, 0, 0, 3'd0, 0, 0, 5'd3, 64'd1 << 56, 64'd0, "R6 R11");
      drive(2'd2, 0, 0, 0, 3'd0, 0, 0, 5'd3, 64'd3 << 56, 64'd0, "R6");
      drive(2'd1, 0, 0, 0, 3'd0, 0, 0, 5'd31, 64'd2, 64'd0, "R6");
      drive(2'd1, 0, 0, 0, 3'd0, 0, 0, 5'd0, 64'd1 << 63, 64'd0, "R6");
      drive(2'd1, 0, 0, 0, 3'd0, 0, 0, 5'd1, 64'd1 << 63, 64'd0, "R6");

      // R7: fetch mask low bit only
      drive(2'd2, 0, 0, 0, 3'd0, 0, 0, 5'd5, 64'd0, 64'd1 << 52, "R7 R10");
      drive(2'd2, 0, 0, 0, 3'd0, 0, 0, 5'd5, 64'd0, 64'd1 << 53, "R7");
      drive(2'd1, 0, 0, 0, 3'd0, 0, 0, 5'd5, 64'd0, 64'd1 << 52, "R7");

      // R10: priority of fetch reasons
      drive(2'd2, 0, 0, 1, 3'd0, 1, 0, 5'd5, 64'd0, 64'd1 << 52, "R10");
      drive(2'd2, 0, 0, 1, 3'd0, 0, 0, 5'd5, 64'd0, 64'd1 << 52, "R10");
      drive(2'd2, 0, 0, 0, 3'd4, 0, 1, 5'd5, 64'd0, 64'd0, "R10");

      // R11: data reason combinations
      drive(2'd1, 0, 0, 1, 3'd1, 0, 0, 5'd9, 64'd1 << 45, 64'd0, "R11");
      drive(2'd0, 0, 0, 1, 3'd0, 0, 0, 5'd9, 64'd1 << 44, 64'd0, "R11");

      // R9: no-access kind never faults
      drive(2'd3, 0, 0, 1, 3'd0, 1, 1, 5'd2, '1, '1, "R9");

      // R9 R8: pseudo-random sweep
      for (int i = 0; i < 200; i++) begin
         logic [31:0] r;
         r = $urandom;
         drive(r[1:0], r[2], r[3], r[4], r[7:5], r[8] & r[9], r[10] & r[11], r[16:12],
               {$urandom, $urandom}, {$urandom, $urandom}, "R9");
      end

      idle(4);
      check("R12", "queue drained", 14'(q_exp.size()), 14'd0);
      finish_run();
   end

endmodule